// File: doc/BRIEF.md
# Two-Port Synchronous RAM with Same-Address Collision Resolution

This block is a word-addressed synchronous memory with two fully symmetric access ports, A and B, on one shared clock. Each port has its own address, write data, per-group write mask, active-low enable, write/read select and output enable. Each port can read or write on any cycle. Read data is registered and shows on the port output in the cycle after the clock edge that sampled the request.

When both ports are enabled on the same word in the same cycle, the block does not leave the result to chance. It applies a fixed outcome and pulses a collision flag for one cycle:
- Two reads both return correct data.
- A read that meets a write returns an all-ones poison word and raises that port's read-error flag, while the write lands normally.
- Two writes destroy the word. It is filled with poison and marked invalid in a per-word valid bit. Until it is rewritten, every read of it raises the read-error flag.

Accesses to different words never interact.

Top module: `twin_port_ram`

## Requirements
- R1: After reset, every word reads as zero with its valid bit set, both data outputs are zero, and both read-error flags and the collision flag are low.
- R2: A port whose active-low enable is high performs no access. A write presented on a disabled port leaves memory unchanged.
- R3: With the enable low and the select low (read), the addressed word appears on the data output one clock after the sampling edge. The output holds that value until the port's next read.
- R4: A data output is zero while its output enable is low. The registered read value is kept and appears when the output enable returns high.
- R5: With the enable low and the select high (write), mask bit g gates data bits [g*GROUP_W +: GROUP_W]. With GROUP_W=4 on a 16-bit word, mask 4'b0101 updates bits 3:0 and 11:8 only.
- R6: With GROUP_W=0 the mask is one bit wide and gates the whole word.
- R7: Two reads of the same word in one cycle both return the stored data, with no read error.
- R8: On a same-word read/write cycle, the reader gets 16'hFFFF and its read-error flag is high for one cycle. The writer's masked data is stored normally.
- R9: Two writes to the same word in one cycle fill the word with all ones and clear its valid bit. Later reads of it raise the read-error flag until a write with at least one mask bit set makes it valid again.
- R10: The collision flag is high for exactly the one cycle after any edge at which both ports were enabled with equal addresses, whatever the access types, and is low otherwise.
- R11: Accesses to different words on the two ports in the same cycle complete independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| aCeN | input | 1 | Port A enable, active low |
| aWe | input | 1 | Port A select: 1 write, 0 read |
| aAddr | input | ADDR_W | Port A word address |
| aDin | input | DATA_W | Port A write data |
| aMask | input | MASK_W | Port A group write mask |
| aOe | input | 1 | Port A output enable, active high |
| aDout | output | DATA_W | Port A read data |
| aRdErr | output | 1 | Port A read-error flag |
| bCeN | input | 1 | Port B enable, active low |
| bWe | input | 1 | Port B select: 1 write, 0 read |
| bAddr | input | ADDR_W | Port B word address |
| bDin | input | DATA_W | Port B write data |
| bMask | input | MASK_W | Port B group write mask |
| bOe | input | 1 | Port B output enable, active high |
| bDout | output | DATA_W | Port B read data |
| bRdErr | output | 1 | Port B read-error flag |
| collision | output | 1 | One-cycle same-address pulse |

## Verification
The assertions take for granted that the enables and selects are held stable across each rising edge. They also assume that both enables are high while reset is applied, so the first post-reset look at the previous cycle sees no access. The stimulus changes every input only on the falling edge and holds both ports disabled throughout reset. Addresses, masks and data are always known values, so the address comparison is never ambiguous.

// File: rtl/twin_ram_pkg.sv
package twin_ram_pkg;

  // strobes from the control half to the storage half, one set per edge
  typedef struct packed {
    logic hit;        // both ports on one word
    logic rdA;
    logic rdB;
    logic wrA;        // store port A data through its mask
    logic wrB;
    logic poisonRdA;  // port A read meets a port B write
    logic poisonRdB;
    logic poisonWr;   // both ports write one word
  } ctrlStrobe_t;

endpackage

// File: rtl/twin_ram_ctrl.sv
module twin_ram_ctrl
  import twin_ram_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aCeN,
  input  logic              aWe,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic              bCeN,
  input  logic              bWe,
  input  logic [ADDR_W-1:0] bAddr,
  output ctrlStrobe_t       strobe,
  output logic              collision
);

  logic aOn, bOn, sameWord;

  assign aOn      = ~aCeN;
  assign bOn      = ~bCeN;
  assign sameWord = (aAddr == bAddr);

  always_comb begin
    strobe           = '0;
    strobe.hit       = aOn & bOn & sameWord;
    strobe.rdA       = aOn & ~aWe;
    strobe.rdB       = bOn & ~bWe;
    strobe.poisonWr  = strobe.hit & aWe & bWe;
    strobe.wrA       = aOn & aWe & ~strobe.poisonWr;
    strobe.wrB       = bOn & bWe & ~strobe.poisonWr;
    strobe.poisonRdA = strobe.rdA & strobe.hit & bWe;
    strobe.poisonRdB = strobe.rdB & strobe.hit & aWe;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) collision <= 1'b0;
    else       collision <= strobe.hit;
  end

  // R10
  collision_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!aCeN && !bCeN && aAddr == bAddr) |=> collision);

  // R10
  collision_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (aCeN || bCeN || aAddr != bAddr) |=> !collision);

endmodule

// File: rtl/twin_ram_store.sv
module twin_ram_store
  import twin_ram_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16,
  parameter int GROUP_W = 4,
  parameter int MASK_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [DATA_W-1:0] aDin,
  input  logic [MASK_W-1:0] aMask,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic [DATA_W-1:0] bDin,
  input  logic [MASK_W-1:0] bMask,
  output logic [DATA_W-1:0] qA,
  output logic [DATA_W-1:0] qB,
  output logic              errA,
  output logic              errB
);

  localparam int DEPTH   = 1 << ADDR_W;
  localparam int SLICE_W = (GROUP_W == 0) ? DATA_W : GROUP_W;
  localparam int GROUPS  = DATA_W / SLICE_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  validBits;
  logic [DATA_W-1:0] aBitEn, bBitEn;

  // expand each mask bit across its slice of the word
  for (genvar g = 0; g < GROUPS; g++) begin : g_slice
    assign aBitEn[g*SLICE_W +: SLICE_W] = {SLICE_W{aMask[g]}};
    assign bBitEn[g*SLICE_W +: SLICE_W] = {SLICE_W{bMask[g]}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      validBits <= '1;
    end else if (strobe.poisonWr) begin
      mem[aAddr]       <= '1;
      validBits[aAddr] <= 1'b0;
    end else begin
      if (strobe.wrA) begin
        mem[aAddr] <= (mem[aAddr] & ~aBitEn) | (aDin & aBitEn);
        if (|aMask) validBits[aAddr] <= 1'b1;
      end
      if (strobe.wrB) begin
        mem[bAddr] <= (mem[bAddr] & ~bBitEn) | (bDin & bBitEn);
        if (|bMask) validBits[bAddr] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qA   <= '0;
      errA <= 1'b0;
    end else if (strobe.rdA) begin
      qA   <= strobe.poisonRdA ? '1 : mem[aAddr];
      errA <= strobe.poisonRdA | ~validBits[aAddr];
    end else begin
      errA <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qB   <= '0;
      errB <= 1'b0;
    end else if (strobe.rdB) begin
      qB   <= strobe.poisonRdB ? '1 : mem[bAddr];
      errB <= strobe.poisonRdB | ~validBits[bAddr];
    end else begin
      errB <= 1'b0;
    end
  end

  // R8
  a_err_poison_chk: assert property (@(posedge clk) disable iff (!rstN)
    errA |-> (qA == '1));

  // R8
  b_err_poison_chk: assert property (@(posedge clk) disable iff (!rstN)
    errB |-> (qB == '1));

  // R9
  ww_invalid_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.poisonWr |=> !validBits[$past(aAddr)]);

  // R3
  err_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errA || errB) |-> ($past(strobe.rdA) || $past(strobe.rdB)));

endmodule

// File: rtl/twin_port_ram.sv
module twin_port_ram
  import twin_ram_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16,
  parameter int GROUP_W = 4,
  parameter int MASK_W  = (GROUP_W == 0) ? 1 : DATA_W / GROUP_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aCeN,
  input  logic              aWe,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [DATA_W-1:0] aDin,
  input  logic [MASK_W-1:0] aMask,
  input  logic              aOe,
  output logic [DATA_W-1:0] aDout,
  output logic              aRdErr,
  input  logic              bCeN,
  input  logic              bWe,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic [DATA_W-1:0] bDin,
  input  logic [MASK_W-1:0] bMask,
  input  logic              bOe,
  output logic [DATA_W-1:0] bDout,
  output logic              bRdErr,
  output logic              collision
);

  ctrlStrobe_t       strobe;
  logic [DATA_W-1:0] qA, qB;

  twin_ram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .aCeN(aCeN), .aWe(aWe), .aAddr(aAddr),
    .bCeN(bCeN), .bWe(bWe), .bAddr(bAddr),
    .strobe(strobe), .collision(collision)
  );

  twin_ram_store #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GROUP_W(GROUP_W), .MASK_W(MASK_W)
  ) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .aAddr(aAddr), .aDin(aDin), .aMask(aMask),
    .bAddr(bAddr), .bDin(bDin), .bMask(bMask),
    .qA(qA), .qB(qB), .errA(aRdErr), .errB(bRdErr)
  );

  assign aDout = aOe ? qA : '0;
  assign bDout = bOe ? qB : '0;

endmodule

// File: tb/twin_port_ram_bench.sv
module twin_port_ram_bench;

  typedef struct {
    logic        en;
    logic        we;
    logic [3:0]  addr;
    logic [15:0] din;
    logic [3:0]  mask;
    logic        oe;
  } portOp_t;

  typedef struct {
    logic [15:0] aD;
    logic        aE;
    logic [15:0] bD;
    logic        bE;
    logic        coll;
    string       tag;
  } expItem_t;

  logic clk = 0;
  logic rstN = 0;
  always #2 clk = ~clk;

  logic aCeN = 1, aWe = 0, aOe = 0, bCeN = 1, bWe = 0, bOe = 0;
  logic [3:0]  aAddr = 0, bAddr = 0, aMask = 0, bMask = 0;
  logic [15:0] aDin = 0, bDin = 0;
  logic [15:0] aDout, bDout;
  logic aRdErr, bRdErr, collision;

  twin_port_ram u_twin_port_ram (
    .clk(clk), .rstN(rstN),
    .aCeN(aCeN), .aWe(aWe), .aAddr(aAddr), .aDin(aDin), .aMask(aMask),
    .aOe(aOe), .aDout(aDout), .aRdErr(aRdErr),
    .bCeN(bCeN), .bWe(bWe), .bAddr(bAddr), .bDin(bDin), .bMask(bMask),
    .bOe(bOe), .bDout(bDout), .bRdErr(bRdErr),
    .collision(collision)
  );

  // whole-word variant for R6
  logic       wCeN = 1, wWe = 0, wOe = 0;
  logic [1:0] wAddr = 0;
  logic [7:0] wDin = 0;
  logic [0:0] wMask = 0;
  logic [7:0] wDout, wDoutB;
  logic       wErr, wErrB, wColl;

  twin_port_ram #(.ADDR_W(2), .DATA_W(8), .GROUP_W(0)) u_whole (
    .clk(clk), .rstN(rstN),
    .aCeN(wCeN), .aWe(wWe), .aAddr(wAddr), .aDin(wDin), .aMask(wMask),
    .aOe(wOe), .aDout(wDout), .aRdErr(wErr),
    .bCeN(1'b1), .bWe(1'b0), .bAddr(2'd0), .bDin(8'd0), .bMask(1'b0),
    .bOe(1'b0), .bDout(wDoutB), .bRdErr(wErrB),
    .collision(wColl)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [15:0] refMem [16];
  logic [15:0] refValid;
  logic [15:0] mqA = 0, mqB = 0;
  expItem_t expQ[$];

  function automatic logic [15:0] bitEn(input logic [3:0] m);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = m[i/4];
    return r;
  endfunction

  function automatic portOp_t rd(input logic [3:0] a, input logic oe);
    portOp_t p;
    p.en = 1; p.we = 0; p.addr = a; p.din = 16'h0; p.mask = 4'h0; p.oe = oe;
    return p;
  endfunction

  function automatic portOp_t wr(input logic [3:0] a, input logic [15:0] d,
                                 input logic [3:0] m);
    portOp_t p;
    p.en = 1; p.we = 1; p.addr = a; p.din = d; p.mask = m; p.oe = 1;
    return p;
  endfunction

  function automatic portOp_t idle(input logic oe);
    portOp_t p;
    p.en = 0; p.we = 0; p.addr = 4'h0; p.din = 16'h0; p.mask = 4'h0; p.oe = oe;
    return p;
  endfunction

  task automatic check(input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: apply one cycle on both ports and push the expected result
  task automatic step(input portOp_t a, input portOp_t b, input string tag);
    expItem_t e;
    logic hit, errA, errB;
    @(negedge clk);
    aCeN = ~a.en; aWe = a.we; aAddr = a.addr; aDin = a.din; aMask = a.mask; aOe = a.oe;
    bCeN = ~b.en; bWe = b.we; bAddr = b.addr; bDin = b.din; bMask = b.mask; bOe = b.oe;
    hit = a.en && b.en && (a.addr == b.addr);
    errA = 0; errB = 0;
    if (a.en && !a.we) begin
      if (hit && b.we) begin mqA = 16'hFFFF; errA = 1; end
      else begin mqA = refMem[a.addr]; errA = ~refValid[a.addr]; end
    end
    if (b.en && !b.we) begin
      if (hit && a.we) begin mqB = 16'hFFFF; errB = 1; end
      else begin mqB = refMem[b.addr]; errB = ~refValid[b.addr]; end
    end
    if (hit && a.we && b.we) begin
      refMem[a.addr] = 16'hFFFF;
      refValid[a.addr] = 0;
    end else begin
      if (a.en && a.we) begin
        refMem[a.addr] = (refMem[a.addr] & ~bitEn(a.mask)) | (a.din & bitEn(a.mask));
        if (|a.mask) refValid[a.addr] = 1;
      end
      if (b.en && b.we) begin
        refMem[b.addr] = (refMem[b.addr] & ~bitEn(b.mask)) | (b.din & bitEn(b.mask));
        if (|b.mask) refValid[b.addr] = 1;
      end
    end
    e.aD = a.oe ? mqA : 16'h0;
    e.aE = errA;
    e.bD = b.oe ? mqB : 16'h0;
    e.bE = errB;
    e.coll = hit;
    e.tag = tag;
    expQ.push_back(e);
  endtask

  // monitor: compare once results have settled after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        check({e.tag, " aDout"}, aDout, e.aD);
        check({e.tag, " aRdErr"}, {15'h0, aRdErr}, {15'h0, e.aE});
        check({e.tag, " bDout"}, bDout, e.bD);
        check({e.tag, " bRdErr"}, {15'h0, bRdErr}, {15'h0, e.bE});
        check({e.tag, " collision"}, {15'h0, collision}, {15'h0, e.coll});
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) refMem[i] = 16'h0;
    refValid = 16'hFFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;

    step(idle(1), idle(1), "R1 reset state");
    step(rd(4'd9, 1), idle(1), "R1 reset word zero");
    step(wr(4'd3, 16'h1234, 4'hF), wr(4'd5, 16'hABCD, 4'hF), "R11 distinct writes");
    step(rd(4'd3, 1), rd(4'd5, 1), "R3 R11 read back");
    step(idle(1), wr(4'd5, 16'h0000, 4'h0), "R3 hold output");
    step(idle(1), idle(1), "R2 prep");
    begin
      portOp_t off;
      off = wr(4'd3, 16'hDEAD, 4'hF);
      off.en = 0;
      step(off, idle(1), "R2 disabled write");
    end
    step(rd(4'd3, 1), idle(1), "R2 unchanged word");
    step(wr(4'd3, 16'h5678, 4'b0101), idle(1), "R5 masked write");
    step(rd(4'd3, 1), idle(1), "R5 masked readback");
    step(rd(4'd5, 0), idle(1), "R4 output disabled");
    step(idle(1), idle(1), "R4 output re-enabled");
    step(rd(4'd5, 1), rd(4'd5, 1), "R7 R10 read-read collision");
    step(idle(1), idle(1), "R10 pulse ends");
    step(rd(4'd3, 1), wr(4'd3, 16'h9999, 4'hF), "R8 read-write collision");
    step(rd(4'd3, 1), idle(1), "R8 write landed");
    step(wr(4'd12, 16'h0F0F, 4'hF), rd(4'd12, 1), "R8 B reads A writes");
    step(wr(4'd7, 16'h1111, 4'hF), wr(4'd7, 16'h2222, 4'hF), "R9 R10 write-write collision");
    step(idle(1), rd(4'd7, 1), "R9 invalid read");
    step(wr(4'd7, 16'h0000, 4'h0), rd(4'd7, 1), "R9 still invalid");
    step(idle(1), rd(4'd7, 1), "R9 still invalid after empty mask");
    step(wr(4'd7, 16'h0042, 4'b0001), idle(1), "R9 rewrite");
    step(idle(1), rd(4'd7, 1), "R9 valid again");
    step(rd(4'd5, 1), wr(4'd6, 16'h7777, 4'hF), "R10 R11 no collision");
    step(idle(1), rd(4'd6, 1), "R11 other word");
    step(idle(1), idle(1), "drain");
    repeat (3) @(posedge clk);

    // R6: whole-word mask on the GROUP_W=0 variant
    @(negedge clk);
    wCeN = 0; wWe = 1; wAddr = 2'd2; wDin = 8'hA5; wMask = 1'b1; wOe = 1;
    @(negedge clk);
    wWe = 1; wDin = 8'h3C; wMask = 1'b0;
    @(negedge clk);
    wWe = 0;
    @(posedge clk);
    #1;
    check("R6 whole-word write", {8'h0, wDout}, 16'h00A5);
    check("R6 read error", {15'h0, wErr}, 16'h0);
    @(negedge clk);
    wCeN = 1;

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule